// File: doc/BRIEF.md
# Crystal-Referenced Motor Speed Discriminator

This block closes the digital part of a brushless motor's speed loop. A squared-up tachometer pulse arrives from the motor, and the block times each of its periods against a crystal clock that has been slowed by a fixed prescaler. The commanded tachometer period is a fixed number of prescaled ticks. The block compares every finished period with a window around that target and issues a speed demand: accelerate, decelerate or idle. A stalled motor, which produces no pulses, drives the period counter to saturation and is treated as running too slow.

A second path compares the tachometer pulse in phase with a free-running reference cycle of the same length. A frequency-only loop settles with a residual speed error, and this phase path pulls the motor into exact step with the reference. A lock flag, active low, reports when the speed has stayed inside the window for several periods in a row.

When the enable input selects stop, every output goes idle, the lock flag is released and all counters restart. Both demand codes feed an external integrator, which is not part of this block.

Top module: `msd_top`

## Requirements
- R1: While rst_ni is low, or in the clock after run_i is sampled low, speed_dmd_o and phase_dmd_o are 2'b00 and lock_no is 1. Stop clears all counters and the lock history. The first tachometer edge after run_i rises only starts timing and changes no demand.
- R2: One prescaled tick occurs every PRESCALE clocks (16 by default), counted from the first clock with run_i high. A period is the number of ticks between two consecutive synchronised rising edges of fg_i.
- R3: A measured period below FAST_LIM ticks (480 by default) sets speed_dmd_o to 2'b10 (decelerate). A period of 479 decelerates.
- R4: A period above SLOW_LIM ticks (544 by default) sets speed_dmd_o to 2'b01 (accelerate). A period from 480 to 544 inclusive sets it to 2'b00 (idle).
- R5: The period counter saturates at 2^CNT_W-1 (1023). When it reaches that value with no edge, speed_dmd_o becomes 2'b01 and lock_no returns to 1.
- R6: The phase reference repeats every REF_TICKS ticks (512), starting at run. phase_dmd_o is 2'b01 from a reference edge until the next tachometer edge, and 2'b10 from a tachometer edge until the next reference edge. It is 2'b00 when both edges coincide or once both have arrived.
- R7: lock_no goes low after LOCK_RUNS (4) consecutive in-window periods. It returns high on the first out-of-window period.
- R8: Outputs are registered. A rise of fg_i first sampled at clock edge k takes effect on the outputs at clock edge k+2.
- R9: speed_dmd_o holds its value between measurements.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Crystal reference clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| run_i | input | 1 | 1 = run, 0 = stop and clear |
| fg_i | input | 1 | Squared tachometer pulse, asynchronous |
| speed_dmd_o | output | 2 | Speed demand: 01 accelerate, 10 decelerate, 00 idle |
| phase_dmd_o | output | 2 | Phase demand, same encoding |
| lock_no | output | 1 | Speed lock flag, active low |

## Verification
A rise of fg_i sampled at clock edge k passes two synchroniser stages and becomes an edge event in the following cycle. The speed, phase and lock registers therefore take the new value at edge k+2. Stop and tick-driven events, such as saturation and reference wrap, appear on the outputs one clock after the cycle in which they occur. The bench's reference model advances once per rising edge using the same sampled inputs, and it compares all three outputs at the falling edge so each result is read in the cycle it falls due. Explicit checks are placed many clocks after each stimulus, once every pending update has settled.

// File: rtl/msd_pkg.sv
package msd_pkg;
  typedef enum logic [1:0] {
    DMD_IDLE = 2'b00,
    DMD_ACC  = 2'b01,
    DMD_DEC  = 2'b10
  } dmd_e;
endpackage

// File: rtl/msd_prescaler.sv
module msd_prescaler #(
  parameter int unsigned DIV = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic tick_o
);
  generate
    if (DIV <= 1) begin : g_bypass
      assign tick_o = run_i;
    end else begin : g_div
      localparam int unsigned PW = $clog2(DIV);
      localparam logic [PW-1:0] LAST = PW'(DIV - 1);
      logic [PW-1:0] pre_q;

      assign tick_o = run_i && (pre_q == LAST);

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)            pre_q <= '0;
        else if (!run_i)        pre_q <= '0;
        else if (pre_q == LAST) pre_q <= '0;
        else                    pre_q <= pre_q + 1'b1;
      end

      // ticks are never back to back when dividing
      assert_tick_gap_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tick_o |=> !tick_o);
    end
  endgenerate
endmodule

// File: rtl/msd_fg_sync.sv
module msd_fg_sync (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fg_i,
  output logic rise_o
);
  logic [2:0] s_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) s_q <= '0;
    else         s_q <= {s_q[1:0], fg_i};
  end

  assign rise_o = s_q[1] & ~s_q[2];

  assert_rise_single_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o);
endmodule

// File: rtl/msd_period_disc.sv
module msd_period_disc
  import msd_pkg::*;
#(
  parameter int unsigned CNT_W     = 10,
  parameter int unsigned FAST_LIM  = 480,
  parameter int unsigned SLOW_LIM  = 544,
  parameter int unsigned LOCK_RUNS = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic tick_i,
  input  logic rise_i,
  output dmd_e spd_o,
  output logic lock_no
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] FAST_C  = CNT_W'(FAST_LIM);
  localparam logic [CNT_W-1:0] SLOW_C  = CNT_W'(SLOW_LIM);
  localparam int unsigned      LK_W    = $clog2(LOCK_RUNS + 1);
  localparam logic [LK_W-1:0]  LK_FULL = LK_W'(LOCK_RUNS);

  logic [CNT_W-1:0] cnt_q, meas;
  logic             valid_q, at_max, sat_ev, in_win;
  logic [LK_W-1:0]  lk_q, lk_nx;
  dmd_e             spd_q;
  logic             lock_n_q;

  assign at_max = (cnt_q == CNT_MAX);
  // period including a tick that lands in the edge cycle
  assign meas   = (tick_i && !at_max) ? cnt_q + 1'b1 : cnt_q;
  assign sat_ev = tick_i && (cnt_q == CNT_MAX - 1'b1) && !rise_i;
  assign in_win = (meas >= FAST_C) && (meas <= SLOW_C);
  assign lk_nx  = (lk_q == LK_FULL) ? lk_q : lk_q + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      valid_q  <= 1'b0;
      lk_q     <= '0;
      spd_q    <= DMD_IDLE;
      lock_n_q <= 1'b1;
    end else if (!run_i) begin
      cnt_q    <= '0;
      valid_q  <= 1'b0;
      lk_q     <= '0;
      spd_q    <= DMD_IDLE;
      lock_n_q <= 1'b1;
    end else if (rise_i) begin
      cnt_q   <= '0;
      valid_q <= 1'b1;
      if (valid_q) begin
        if (meas < FAST_C)      spd_q <= DMD_DEC;
        else if (meas > SLOW_C) spd_q <= DMD_ACC;
        else                    spd_q <= DMD_IDLE;
        if (in_win) begin
          lk_q     <= lk_nx;
          lock_n_q <= (lk_nx != LK_FULL);
        end else begin
          lk_q     <= '0;
          lock_n_q <= 1'b1;
        end
      end
    end else begin
      if (tick_i && !at_max) cnt_q <= cnt_q + 1'b1;
      if (sat_ev) begin
        spd_q    <= DMD_ACC;
        lk_q     <= '0;
        lock_n_q <= 1'b1;
      end
    end
  end

  assign spd_o   = spd_q;
  assign lock_no = lock_n_q;

  assert_stop_idle_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> (spd_q == DMD_IDLE) && lock_n_q);
  assert_legal_code_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    spd_q != 2'b11);
  assert_lock_on_window_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(lock_n_q) |-> $past(run_i && rise_i && valid_q && in_win));
  assert_sat_acc_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && sat_ev) |=> (spd_q == DMD_ACC) && lock_n_q);
endmodule

// File: rtl/msd_phase_cmp.sv
module msd_phase_cmp
  import msd_pkg::*;
#(
  parameter int unsigned REF_TICKS = 512
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic tick_i,
  input  logic rise_i,
  output dmd_e phase_o
);
  localparam int unsigned    RW   = $clog2(REF_TICKS);
  localparam logic [RW-1:0]  LAST = RW'(REF_TICKS - 1);

  logic [RW-1:0] ref_q;
  logic          ref_ev, ref_f_q, fg_f_q, ref_nx, fg_nx, both;
  dmd_e          ph_q;

  assign ref_ev = tick_i && (ref_q == LAST);
  assign both   = (ref_f_q | ref_ev) & (fg_f_q | rise_i);
  assign ref_nx = (ref_f_q | ref_ev) & ~both;
  assign fg_nx  = (fg_f_q | rise_i) & ~both;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ref_q   <= '0;
      ref_f_q <= 1'b0;
      fg_f_q  <= 1'b0;
      ph_q    <= DMD_IDLE;
    end else if (!run_i) begin
      ref_q   <= '0;
      ref_f_q <= 1'b0;
      fg_f_q  <= 1'b0;
      ph_q    <= DMD_IDLE;
    end else begin
      if (tick_i) ref_q <= ref_ev ? '0 : ref_q + 1'b1;
      ref_f_q <= ref_nx;
      fg_f_q  <= fg_nx;
      ph_q    <= ref_nx ? DMD_ACC : (fg_nx ? DMD_DEC : DMD_IDLE);
    end
  end

  assign phase_o = ph_q;

  assert_flags_exclusive_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ref_f_q && fg_f_q));
  assert_phase_stop_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> ph_q == DMD_IDLE);
endmodule

// File: rtl/msd_top.sv
module msd_top
  import msd_pkg::*;
#(
  parameter int unsigned PRESCALE  = 16,
  parameter int unsigned REF_TICKS = 512,
  parameter int unsigned CNT_W     = 10,
  parameter int unsigned FAST_LIM  = 480,
  parameter int unsigned SLOW_LIM  = 544,
  parameter int unsigned LOCK_RUNS = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       run_i,
  input  logic       fg_i,
  output logic [1:0] speed_dmd_o,
  output logic [1:0] phase_dmd_o,
  output logic       lock_no
);
  logic tick, rise;
  dmd_e spd, ph;

  msd_prescaler #(.DIV(PRESCALE)) u_pre (
    .clk_i, .rst_ni, .run_i, .tick_o(tick)
  );

  msd_fg_sync u_sync (
    .clk_i, .rst_ni, .fg_i, .rise_o(rise)
  );

  msd_period_disc #(
    .CNT_W(CNT_W), .FAST_LIM(FAST_LIM), .SLOW_LIM(SLOW_LIM), .LOCK_RUNS(LOCK_RUNS)
  ) u_disc (
    .clk_i, .rst_ni, .run_i, .tick_i(tick), .rise_i(rise), .spd_o(spd), .lock_no
  );

  msd_phase_cmp #(.REF_TICKS(REF_TICKS)) u_phase (
    .clk_i, .rst_ni, .run_i, .tick_i(tick), .rise_i(rise), .phase_o(ph)
  );

  assign speed_dmd_o = spd;
  assign phase_dmd_o = ph;
endmodule

// File: tb/msd_top_bench.sv
module msd_top_bench;
  localparam int P  = 2;
  localparam int RT = 512;
  localparam int CMAX = 1023;

  logic clk = 1'b0, rst_n = 1'b0, run = 1'b0, fg = 1'b0;
  logic [1:0] spd_o, ph_o;
  logic lock_n;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  msd_top #(.PRESCALE(P)) u_msd_top (
    .clk_i(clk), .rst_ni(rst_n), .run_i(run), .fg_i(fg),
    .speed_dmd_o(spd_o), .phase_dmd_o(ph_o), .lock_no(lock_n)
  );

  // behavioural reference model
  int pre, per, lk, refc, m_spd, m_ph, m_lockn, meas;
  bit valid, rf, ff, tick, edg, refev, r, f;
  bit sq[$] = '{0, 0, 0};

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre = 0; per = 0; lk = 0; refc = 0; m_spd = 0; m_ph = 0; m_lockn = 1;
      valid = 0; rf = 0; ff = 0; sq = '{0, 0, 0};
    end else begin
      tick  = run && (pre == P - 1);
      edg   = sq[1] && !sq[2];
      refev = tick && (refc == RT - 1);
      sq.push_front(fg); void'(sq.pop_back());
      if (!run) begin
        pre = 0; per = 0; lk = 0; refc = 0; m_spd = 0; m_ph = 0; m_lockn = 1;
        valid = 0; rf = 0; ff = 0;
      end else begin
        pre  = (pre == P - 1) ? 0 : pre + 1;
        meas = per + ((tick && per < CMAX) ? 1 : 0);
        if (edg) begin
          if (valid) begin
            m_spd = (meas < 480) ? 2 : (meas > 544) ? 1 : 0;
            if (meas >= 480 && meas <= 544) begin
              lk = (lk < 4) ? lk + 1 : 4;
              m_lockn = (lk < 4);
            end else begin
              lk = 0; m_lockn = 1;
            end
          end
          valid = 1; per = 0;
        end else begin
          if (tick && per == CMAX - 1) begin m_spd = 1; lk = 0; m_lockn = 1; end
          if (tick && per < CMAX) per++;
        end
        r = rf || refev; f = ff || edg;
        if (r && f) begin r = 0; f = 0; end
        rf = r; ff = f;
        m_ph = r ? 1 : (f ? 2 : 0);
        if (tick) refc = (refc == RT - 1) ? 0 : refc + 1;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      checks++;
      if (spd_o !== 2'(m_spd)) begin
        errors++; $display("FAIL R8 R4 speed act=%0d exp=%0d t=%0t", spd_o, m_spd, $time);
      end
      if (ph_o !== 2'(m_ph)) begin
        errors++; $display("FAIL R8 R6 phase act=%0d exp=%0d t=%0t", ph_o, m_ph, $time);
      end
      if (lock_n !== 1'(m_lockn)) begin
        errors++; $display("FAIL R8 R7 lock act=%0d exp=%0d t=%0t", lock_n, m_lockn, $time);
      end
    end
  end

  task automatic check(input string req, input logic [1:0] act, input logic [1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++; $display("FAIL %s act=%0d exp=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic fg_period(input int ticks, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) fg = 1'b1;
      repeat (7) @(negedge clk);
      fg = 1'b0;
      repeat (P * ticks - 8) @(negedge clk);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    int cyc = 0;
    while (!done && cyc < 150000) begin @(posedge clk); cyc++; end
    if (!done) begin
      errors++; done = 1;
      $display("FAIL watchdog act=%0d exp=0", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    wait_clk(4);
    check("R1 reset speed", spd_o, 2'b00);
    check("R1 reset phase", ph_o, 2'b00);
    check("R1 reset lock", {1'b0, lock_n}, 2'b01);
    rst_n = 1'b1;
    wait_clk(2);
    run = 1'b1;
    fg_period(512, 6);
    check("R4 nominal idle", spd_o, 2'b00);
    check("R7 lock after runs", {1'b0, lock_n}, 2'b00);
    fg_period(460, 2);
    check("R3 fast decel", spd_o, 2'b10);
    check("R7 lock lost", {1'b0, lock_n}, 2'b01);
    fg_period(479, 3);
    check("R3 479 decel", spd_o, 2'b10);
    fg_period(480, 3);
    check("R4 480 idle", spd_o, 2'b00);
    fg_period(544, 3);
    check("R4 544 idle", spd_o, 2'b00);
    fg_period(545, 3);
    check("R4 545 accel", spd_o, 2'b01);
    fg_period(560, 2);
    check("R4 slow accel", spd_o, 2'b01);
    fg_period(512, 4);
    check("R7 three runs no lock", {1'b0, lock_n}, 2'b01);
    check("R9 idle holds", spd_o, 2'b00);
    fg_period(512, 1);
    check("R7 fourth run locks", {1'b0, lock_n}, 2'b00);
    // stop
    run = 1'b0;
    wait_clk(3);
    check("R1 stop speed", spd_o, 2'b00);
    check("R1 stop lock", {1'b0, lock_n}, 2'b01);
    check("R1 stop phase", ph_o, 2'b00);
    // restart: FG leads reference
    run = 1'b1;
    wait_clk(100);
    fg = 1'b1; wait_clk(8); fg = 1'b0;
    wait_clk(92);
    check("R1 first edge no demand", spd_o, 2'b00);
    check("R6 fg leads decel", ph_o, 2'b10);
    wait_clk(900);
    check("R6 ref arrives idle", ph_o, 2'b00);
    wait_clk(1000);
    check("R6 fg lags accel", ph_o, 2'b01);
    check("R9 speed holds stalled", spd_o, 2'b00);
    wait_clk(300);
    check("R5 stall accel", spd_o, 2'b01);
    check("R5 stall unlocked", {1'b0, lock_n}, 2'b01);
    wait_clk(4);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule